// File: doc/BRIEF.md
# Permission-Aware Set-Associative Tag Directory

This block keeps the tag side of a set-associative cache. For every way of every set it stores a valid flag, the upper line-address bits, a two-bit permission level and the context id of the current lock owner. A controller issues one command per cycle on a request port: a command code, a line-aligned address, a request kind, a context id and a permission value. One cycle later the block returns a registered response with a success flag, an error flag, a way number and, for victim queries, a reconstructed line address.

A line counts as present only when it is valid, its stored tag matches and its permission is not the absent level. An access is judged against the permission level and the request kind. A true-LRU tracker per set picks victims. Both allocation and any access that matches a present line refresh the LRU order, even when the permission check then refuses the access.

Top module: `tagdir`

## Requirements
- R1: The number of sets is CACHE_BYTES / WAYS / LINE_BYTES and must be at least 2. The set index is the field addr[INDEX_LSB +: log2(sets)]. The stored tag is every address bit above that field, so a tag placed in one set is never seen from another set.
- R2: Permission codes are 0 = absent, 1 = invalid, 2 = read-only and 3 = read-write. A probe (command 2) reports ok=1 only for a way that is valid, has a matching tag and holds a permission other than absent. A line in the absent state is treated as missing by every lookup.
- R3: An access (command 1) uses request kinds 0 = load, 1 = instruction fetch and 2 = store. It reports ok=1 when the present line is read-write, or when the line is read-only and the kind is load or fetch. A store to a read-only line, any access to an invalid line and any miss all report ok=0.
- R4: An access or a touch (command 7) that matches a present line makes that way the most recently used, whether or not the access is permitted.
- R5: The availability check (command 3) reports ok=1 when a valid way already holds the tag, or when some way is not valid or holds the absent permission.
- R6: A successful allocation (command 4) writes into the lowest-numbered way that is not valid or is absent. It sets that way to permission invalid, sets the lock owner to the all-ones unlocked value, makes the way most recently used and reports that way.
- R7: Allocating a tag that is already present, or allocating into a set with no free way, sets err=1 and changes no state.
- R8: Deallocation (command 5) of a present line clears its valid flag and sets its permission to absent. Deallocating a missing line sets err=1.
- R9: Replacement is true LRU. After reset the ages in each set are equal to the way numbers. A touch gives the touched way age 0 and adds one to every way that was younger than it. The victim query (command 6) returns the way with the oldest age and its line address. The query sets err=1 when the set still has an available way.
- R10: Lock set (command 8) stores the request context as owner. Lock clear (command 9) stores all ones. Lock test (command 10) reports ok=1 only when the stored owner equals the request context. All three set err=1 for a missing line.
- R11: Permission write (command 11) replaces the permission of a present line with the request permission. It sets err=1 for a missing line.
- R12: Each request with req_valid=1 produces rsp_valid=1 on the next cycle, and no request produces rsp_valid=0. When err=1, ok is 0. Command 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 4 | Command code |
| req_addr | input | ADDR_W | Line-aligned address |
| req_kind | input | 2 | Access kind for command 1 |
| req_ctx | input | CTX_W | Context id for lock commands |
| req_perm | input | 2 | Permission for command 11 |
| rsp_valid | output | 1 | Response strobe |
| rsp_ok | output | 1 | Result / success flag |
| rsp_err | output | 1 | Illegal-command flag |
| rsp_way | output | WAY_W | Matched, allocated or victim way |
| rsp_addr | output | ADDR_W | Victim line address |

## Verification
The assertions check on every cycle that:
- each request gets exactly one response, one cycle later;
- an error always clears the success flag;
- query commands never raise an error;
- a victim query against a set with a free way is refused;
- a tag is never present in two ways of the same set at once, which shows that duplicate allocation is blocked.

Only the bench scenarios can show the rest: the permission-versus-kind decisions, the lowest-free-way placement, the LRU order after a series of touches (including touches from refused accesses), the victim addresses, the lock owner being cleared by allocation, and the isolation between sets. The bench checks these against a reference model over directed sequences and a long random run that uses a small pool of tags, so that conflicts are frequent.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_ACCESS    = 4'd1,
    OP_PROBE     = 4'd2,
    OP_AVAIL     = 4'd3,
    OP_ALLOC     = 4'd4,
    OP_DEALLOC   = 4'd5,
    OP_VICTIM    = 4'd6,
    OP_TOUCH     = 4'd7,
    OP_LOCK_SET  = 4'd8,
    OP_LOCK_CLR  = 4'd9,
    OP_LOCK_TEST = 4'd10,
    OP_PERM_WR   = 4'd11
  } op_e;

  typedef enum logic [1:0] {
    PERM_ABSENT = 2'd0,
    PERM_INVAL  = 2'd1,
    PERM_RD     = 2'd2,
    PERM_RDWR   = 2'd3
  } perm_e;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'd0,
    KIND_FETCH = 2'd1,
    KIND_STORE = 2'd2
  } kind_e;
endpackage

// File: rtl/tagdir_set_match.sv
module tagdir_set_match import tagdir_pkg::*; #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 24,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]       way_vld,
  input  logic [WAYS*TAG_W-1:0] way_tags,
  input  logic [2*WAYS-1:0]     way_perms,
  input  logic [TAG_W-1:0]      req_tag,
  output logic [WAYS-1:0]       hit_vec,
  output logic                  hit_any,
  output logic [WAY_W-1:0]      hit_way,
  output logic                  free_any,
  output logic [WAY_W-1:0]      free_way,
  output logic                  avail
);
  logic [WAYS-1:0] same_vec;
  logic [WAYS-1:0] free_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic tag_eq;
    logic absent;
    assign tag_eq      = way_tags[w*TAG_W +: TAG_W] == req_tag;
    assign absent      = way_perms[2*w +: 2] == PERM_ABSENT;
    assign same_vec[w] = way_vld[w] && tag_eq;
    assign hit_vec[w]  = same_vec[w] && !absent;
    assign free_vec[w] = !way_vld[w] || absent;
  end

  assign hit_any  = |hit_vec;
  assign free_any = |free_vec;
  assign avail    = (|same_vec) || free_any;

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])  hit_way  = WAY_W'(w);
      if (free_vec[w]) free_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/tagdir_lru.sv
module tagdir_lru #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int SET_W = 2,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim_way
);
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAY_W-1:0] age_d [WAYS];
  logic [WAY_W-1:0] ref_age;

  always_comb begin
    ref_age    = age_q[rd_set][touch_way];
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == touch_way)         age_d[w] = '0;
      else if (age_q[rd_set][w] < ref_age) age_d[w] = age_q[rd_set][w] + 1'b1;
      else                                 age_d[w] = age_q[rd_set][w];
      if (age_q[rd_set][w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++)
        age_q[rd_set][w] <= age_d[w];
    end
  end
endmodule

// File: rtl/tagdir.sv
module tagdir import tagdir_pkg::*; #(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int CACHE_BYTES = 1024,
  parameter int WAYS        = 4,
  parameter int INDEX_LSB   = 6,
  parameter int CTX_W       = 4,
  localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [1:0]        req_perm,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic              rsp_err,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [ADDR_W-1:0] rsp_addr
);
  localparam int SETS    = CACHE_BYTES / WAYS / LINE_BYTES;
  localparam int SET_W   = $clog2(SETS);
  localparam int TAG_LSB = INDEX_LSB + SET_W;
  localparam int TAG_W   = ADDR_W - TAG_LSB;

  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] tag;
    perm_e            perm;
    logic [CTX_W-1:0] own;
  } line_t;

  localparam line_t LINE_RESET = '{vld: 1'b0, tag: '0, perm: PERM_ABSENT, own: '1};

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] req_tag;
  assign set_idx = req_addr[INDEX_LSB +: SET_W];
  assign req_tag = req_addr[TAG_LSB +: TAG_W];

  line_t lines_q [SETS][WAYS];

  logic [WAYS-1:0]       set_vld;
  logic [WAYS*TAG_W-1:0] set_tags;
  logic [2*WAYS-1:0]     set_perms;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_vld[w]                 = lines_q[set_idx][w].vld;
      set_tags[w*TAG_W +: TAG_W] = lines_q[set_idx][w].tag;
      set_perms[2*w +: 2]        = lines_q[set_idx][w].perm;
    end
  end

  logic [WAYS-1:0]  hit_vec;
  logic             hit_any, free_any, avail;
  logic [WAY_W-1:0] hit_way, free_way, victim_way;

  tagdir_set_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .way_vld(set_vld), .way_tags(set_tags), .way_perms(set_perms),
    .req_tag(req_tag), .hit_vec(hit_vec), .hit_any(hit_any), .hit_way(hit_way),
    .free_any(free_any), .free_way(free_way), .avail(avail)
  );

  logic             touch_en;
  logic [WAY_W-1:0] touch_way;

  tagdir_lru #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_lru (
    .clk(clk), .rst_n(rst_n), .rd_set(set_idx), .touch_en(touch_en),
    .touch_way(touch_way), .victim_way(victim_way)
  );

  line_t            hit_line, wr_line;
  logic             wr_en;
  logic [WAY_W-1:0] wr_way;
  logic             ok_d, err_d;
  logic [WAY_W-1:0] way_d;
  logic [ADDR_W-1:0] addr_d;
  logic             perm_pass;

  assign hit_line  = lines_q[set_idx][hit_way];
  assign perm_pass = (hit_line.perm == PERM_RDWR) ||
                     ((hit_line.perm == PERM_RD) && (req_kind != KIND_STORE));

  always_comb begin
    ok_d      = 1'b0;
    err_d     = 1'b0;
    way_d     = hit_way;
    addr_d    = '0;
    touch_en  = 1'b0;
    touch_way = hit_way;
    wr_en     = 1'b0;
    wr_way    = hit_way;
    wr_line   = hit_line;
    if (req_valid) begin
      case (req_op)
        OP_ACCESS: begin
          ok_d     = hit_any && perm_pass;
          touch_en = hit_any;
        end
        OP_PROBE: ok_d = hit_any;
        OP_AVAIL: ok_d = avail;
        OP_ALLOC: begin
          if (hit_any || !free_any) err_d = 1'b1;
          else begin
            ok_d      = 1'b1;
            way_d     = free_way;
            touch_en  = 1'b1;
            touch_way = free_way;
            wr_en     = 1'b1;
            wr_way    = free_way;
            wr_line   = '{vld: 1'b1, tag: req_tag, perm: PERM_INVAL, own: '1};
          end
        end
        OP_DEALLOC: begin
          if (!hit_any) err_d = 1'b1;
          else begin
            ok_d         = 1'b1;
            wr_en        = 1'b1;
            wr_line.vld  = 1'b0;
            wr_line.perm = PERM_ABSENT;
          end
        end
        OP_VICTIM: begin
          if (avail) err_d = 1'b1;
          else begin
            ok_d   = 1'b1;
            way_d  = victim_way;
            addr_d = ADDR_W'({lines_q[set_idx][victim_way].tag, set_idx}) << INDEX_LSB;
          end
        end
        OP_TOUCH: begin
          ok_d     = hit_any;
          touch_en = hit_any;
        end
        OP_LOCK_SET, OP_LOCK_CLR: begin
          if (!hit_any) err_d = 1'b1;
          else begin
            ok_d        = 1'b1;
            wr_en       = 1'b1;
            wr_line.own = (req_op == OP_LOCK_SET) ? req_ctx : '1;
          end
        end
        OP_LOCK_TEST: begin
          if (!hit_any) err_d = 1'b1;
          else ok_d = hit_line.own == req_ctx;
        end
        OP_PERM_WR: begin
          if (!hit_any) err_d = 1'b1;
          else begin
            ok_d         = 1'b1;
            wr_en        = 1'b1;
            wr_line.perm = perm_e'(req_perm);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          lines_q[s][w] <= LINE_RESET;
    end else if (wr_en) begin
      lines_q[set_idx][wr_way] <= wr_line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_way   <= '0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_ok    <= ok_d;
      rsp_err   <= err_d;
      if (req_valid) begin
        rsp_way  <= way_d;
        rsp_addr <= addr_d;
      end
    end
  end
endmodule

// File: rtl/tagdir_chk.sv
module tagdir_chk import tagdir_pkg::*; #(
  parameter int WAYS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [3:0]      req_op,
  input logic            rsp_valid,
  input logic            rsp_ok,
  input logic            rsp_err,
  input logic [WAYS-1:0] hit_vec,
  input logic            avail
);
  logic is_query;
  assign is_query = (req_op == OP_ACCESS) || (req_op == OP_PROBE) ||
                    (req_op == OP_AVAIL)  || (req_op == OP_TOUCH);

  assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_rsp_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_err_clears_ok_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> !rsp_ok);

  assert_query_no_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_query) |=> !rsp_err);

  assert_unique_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_victim_needs_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_VICTIM && avail) |=> (rsp_err && !rsp_ok));
endmodule

bind tagdir tagdir_chk #(.WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_err(rsp_err),
  .hit_vec(hit_vec), .avail(avail)
);

// File: tb/tagdir_bench.sv
module tagdir_bench;
  localparam int SETS = 4;
  localparam int WAYS = 4;
  localparam int TAG_LSB = 8;
  localparam int UNLK = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_op = '0;
  logic [31:0] req_addr = '0;
  logic [1:0] req_kind = '0;
  logic [3:0] req_ctx = '0;
  logic [1:0] req_perm = '0;
  logic rsp_valid, rsp_ok, rsp_err;
  logic [1:0] rsp_way;
  logic [31:0] rsp_addr;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  tagdir u_tagdir (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_kind(req_kind), .req_ctx(req_ctx), .req_perm(req_perm),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_err(rsp_err),
    .rsp_way(rsp_way), .rsp_addr(rsp_addr)
  );

  bit mv [SETS][WAYS];
  int mt [SETS][WAYS];
  int mp [SETS][WAYS];
  int mo [SETS][WAYS];
  int ma [SETS][WAYS];

  task automatic chk(bit good, string rq, longint act, longint exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int m_find(int s, int t);
    for (int w = 0; w < WAYS; w++)
      if (mv[s][w] && mp[s][w] != 0 && mt[s][w] == t) return w;
    return -1;
  endfunction

  function automatic int m_free(int s);
    for (int w = 0; w < WAYS; w++)
      if (!mv[s][w] || mp[s][w] == 0) return w;
    return -1;
  endfunction

  function automatic bit m_avail(int s, int t);
    for (int w = 0; w < WAYS; w++)
      if ((mv[s][w] && mt[s][w] == t) || !mv[s][w] || mp[s][w] == 0) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int m_victim(int s);
    for (int w = 0; w < WAYS; w++)
      if (ma[s][w] == WAYS - 1) return w;
    return 0;
  endfunction

  task automatic m_touch(int s, int w);
    int r = ma[s][w];
    for (int j = 0; j < WAYS; j++) begin
      if (j == w) ma[s][j] = 0;
      else if (ma[s][j] < r) ma[s][j]++;
    end
  endtask

  function automatic logic [31:0] mk(int s, int t);
    return (32'(t) << TAG_LSB) | (32'(s) << 6);
  endfunction

  task automatic run(int opc, int s, int t, int kind, int ctx, int perm, string rq);
    int hw = m_find(s, t);
    int fw = m_free(s);
    bit av = m_avail(s, t);
    int vw = m_victim(s);
    bit e_ok = 0, e_err = 0;
    int e_way = -1;
    bit c_addr = 0;
    logic [31:0] e_addr = '0;
    case (opc)
      1: begin e_ok = hw >= 0 && (mp[s][hw] == 3 || (mp[s][hw] == 2 && kind != 2)); e_way = hw; end
      2, 7: begin e_ok = hw >= 0; e_way = hw; end
      3: e_ok = av;
      4: if (hw >= 0 || fw < 0) e_err = 1; else begin e_ok = 1; e_way = fw; end
      5, 8, 9, 11: if (hw < 0) e_err = 1; else begin e_ok = 1; e_way = hw; end
      6: if (av) e_err = 1; else begin
           e_ok = 1; e_way = vw; c_addr = 1; e_addr = mk(s, mt[s][vw]);
         end
      10: if (hw < 0) e_err = 1; else begin e_ok = mo[s][hw] == ctx; e_way = hw; end
      default: ;
    endcase
    @(negedge clk);
    req_valid = 1'b1;
    req_op = 4'(opc);
    req_addr = mk(s, t);
    req_kind = 2'(kind);
    req_ctx = 4'(ctx);
    req_perm = 2'(perm);
    @(posedge clk);
    #1;
    chk(rsp_valid == 1'b1, {rq, " valid"}, rsp_valid, 1);
    chk(rsp_ok == e_ok, {rq, " ok"}, rsp_ok, e_ok);
    chk(rsp_err == e_err, {rq, " err"}, rsp_err, e_err);
    if (e_way >= 0) chk(rsp_way == 2'(e_way), {rq, " way"}, rsp_way, e_way);
    if (c_addr) chk(rsp_addr == e_addr, {rq, " addr"}, rsp_addr, e_addr);
    case (opc)
      1, 7: if (hw >= 0) m_touch(s, hw);
      4: if (!e_err) begin
           mv[s][fw] = 1; mt[s][fw] = t; mp[s][fw] = 1; mo[s][fw] = UNLK; m_touch(s, fw);
         end
      5: if (!e_err) begin mv[s][hw] = 0; mp[s][hw] = 0; end
      8: if (!e_err) mo[s][hw] = ctx;
      9: if (!e_err) mo[s][hw] = UNLK;
      11: if (!e_err) mp[s][hw] = perm;
      default: ;
    endcase
  endtask

  function automatic string req_of(int opc);
    case (opc)
      1: return "R3";
      2: return "R2";
      3: return "R5";
      4: return "R6";
      5: return "R8";
      6: return "R9";
      7: return "R4";
      8, 9, 10: return "R10";
      11: return "R11";
      default: return "R12";
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam int TA = 11, TB = 48, TC = 85, TD = 122, TE = 159;

  initial begin
    int seed = 32'h5eed1;
    void'($urandom(seed));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        mv[s][w] = 0; mt[s][w] = 0; mp[s][w] = 0; mo[s][w] = UNLK; ma[s][w] = w;
      end
    repeat (3) @(posedge clk);
    #1;
    chk(rsp_valid == 0 && rsp_err == 0 && rsp_ok == 0, "R12 reset", rsp_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;

    run(2, 1, TA, 0, 0, 0, "R2 probe empty");
    run(6, 1, TA, 0, 0, 0, "R9 victim on free set");
    run(4, 1, TA, 0, 0, 0, "R6 alloc first");
    run(2, 1, TA, 0, 0, 0, "R2 probe invalid line");
    run(2, 2, TA, 0, 0, 0, "R1 other set");
    run(1, 1, TA, 0, 0, 0, "R3 load invalid");
    run(11, 1, TA, 0, 0, 2, "R11 set ro");
    run(1, 1, TA, 0, 0, 0, "R3 load ro");
    run(1, 1, TA, 1, 0, 0, "R3 fetch ro");
    run(1, 1, TA, 2, 0, 0, "R3 store ro");
    run(11, 1, TA, 0, 0, 3, "R11 set rw");
    run(1, 1, TA, 2, 0, 0, "R3 store rw");
    run(4, 1, TA, 0, 0, 0, "R7 dup alloc");
    run(10, 1, TA, 0, 5, 0, "R10 test unlocked");
    run(8, 1, TA, 0, 5, 0, "R10 lock set");
    run(10, 1, TA, 0, 5, 0, "R10 test owner");
    run(10, 1, TA, 0, 3, 0, "R10 test other");
    run(9, 1, TA, 0, 0, 0, "R10 lock clr");
    run(10, 1, TA, 0, 5, 0, "R10 test cleared");
    run(8, 1, TB, 0, 5, 0, "R10 lock absent");
    run(4, 1, TB, 0, 0, 0, "R6 alloc 2");
    run(4, 1, TC, 0, 0, 0, "R6 alloc 3");
    run(4, 1, TD, 0, 0, 0, "R6 alloc 4");
    run(3, 1, TE, 0, 0, 0, "R5 avail full");
    run(3, 1, TB, 0, 0, 0, "R5 avail present");
    run(4, 1, TE, 0, 0, 0, "R7 alloc full");
    run(2, 1, TE, 0, 0, 0, "R7 state kept");
    run(6, 1, TE, 0, 0, 0, "R9 victim");
    run(1, 1, TA, 2, 0, 0, "R4 touch via access");
    run(6, 1, TE, 0, 0, 0, "R9 victim after access");
    run(8, 1, TC, 0, 7, 0, "R10 lock c");
    run(11, 1, TC, 0, 0, 0, "R2 make absent");
    run(2, 1, TC, 0, 0, 0, "R2 absent hidden");
    run(3, 1, TE, 0, 0, 0, "R5 avail absent way");
    run(4, 1, TE, 0, 0, 0, "R6 reuse absent way");
    run(10, 1, TE, 0, 7, 0, "R6 lock cleared");
    run(5, 1, TB, 0, 0, 0, "R8 dealloc");
    run(2, 1, TB, 0, 0, 0, "R8 probe gone");
    run(5, 1, TB, 0, 0, 0, "R8 dealloc absent");
    run(7, 1, TD, 0, 0, 0, "R4 touch");
    run(0, 1, TD, 0, 0, 0, "R12 nop");
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    chk(rsp_valid == 0, "R12 idle", rsp_valid, 0);

    for (int i = 0; i < 4000; i++) begin
      int opc = $urandom_range(11, 1);
      int s = $urandom_range(SETS - 1, 0);
      int t = 11 + 37 * $urandom_range(5, 0);
      if (opc == 4 && $urandom_range(1, 0) == 1) opc = 4;
      run(opc, s, t, $urandom_range(2, 0), $urandom_range(15, 0),
          $urandom_range(3, 0), req_of(opc));
    end
    @(negedge clk);
    req_valid = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule